// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column sequence for one SDRAM burst. A one-cycle start strobe captures an 8-bit start column together with the mode inputs for the burst. The mode inputs are the length code and the ordering select. From the next clock onward, the block presents one column per cycle with a valid strobe. It raises a done flag on the beat that closes the burst. The same logic serves two uses: the column counter inside a memory model, and the address prediction inside a controller that tracks what a device will access.

Finite bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the start column. In sequential order the low bits count upward and wrap within that block. In interleaved order each beat is the start column XOR the beat number. Full-page mode walks all 256 columns in sequential order, wrapping from the top column to column 0. It runs until a stop or a new start arrives. A new start always takes over on the following clock, so bursts can be chained with no idle cycle.

The length code and the ordering select are captured only with the start strobe. Changing them during a burst does not affect the burst in progress.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held, `burst_valid` and `burst_done` are 0.
- R2: The cycle after `start` is sampled high, `burst_valid` is 1 and `col_out` equals the `start_col` that was captured.
- R3: Sequential order (`ilv_sel`=0) for a finite length BL keeps the column bits above log2(BL) unchanged. It adds the beat number to the low log2(BL) bits, modulo BL. For example, BL=4 from 0x2E gives 0x2E,0x2F,0x2C,0x2D.
- R4: Interleaved order (`ilv_sel`=1) for a finite length BL gives start_col XOR beat on beat 0..BL-1. For example, BL=8 from 0x35 gives 0x35,0x34,0x37,0x36,0x31,0x30,0x33,0x32.
- R5: `len_sel` codes 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. With no stop and no new start, `burst_valid` stays high for exactly that many cycles and then falls.
- R6: In a finite burst, `burst_done` is 1 on the final beat and 0 on every other beat.
- R7: Any `len_sel` code with bit 2 set selects full page. The column counts upward by one per cycle across all 256 columns and wraps from 0xFF to 0x00. It keeps going past 256 beats, ignores `ilv_sel`, and never raises `burst_done` without a stop.
- R8: `stop` high during a valid beat, with no `start` in the same cycle, raises `burst_done` in that cycle and drops `burst_valid` on the next. `stop` while idle has no effect.
- R9: `start` during an active burst ends it after the current beat, and the new burst's first column appears on the next cycle. `len_sel` and `ilv_sel` changes between starts do not alter a running burst.
- R10: `start` on the final beat of a burst chains the next burst with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a new burst from `start_col` |
| start_col | input | 8 | First column of the burst |
| len_sel | input | 3 | Length code: 0..3 give 1/2/4/8 beats, bit 2 set gives full page |
| ilv_sel | input | 1 | 0 sequential, 1 interleaved (finite lengths only) |
| stop | input | 1 | Terminate the running burst on this beat |
| col_out | output | 8 | Column of the current beat |
| burst_valid | output | 1 | A beat is presented this cycle |
| burst_done | output | 1 | This beat is the last of the burst |

## Verification
The bench targets these corner cases:
- Start columns near the top of an aligned block. A counter that carried into the upper bits would leave the block instead of wrapping inside it.
- An interleaved pattern whose start column has odd low bits. This catches an adder used where an XOR is needed.
- A full-page run of more than 256 beats that starts at 0xFE with interleave requested. A design that capped the count, honoured the ordering select or pulsed done would show wrong columns or a stray done.
- A restart in mid-burst, a chained start on the final beat, a stop, a stop while idle, and mode inputs changed after capture. These expose off-by-one endings, idle gaps between chained bursts, and mode registers that were not captured at start.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef struct packed {
    logic       page;   // full-page run
    logic [1:0] lg;     // log2 of finite length
    logic       ilv;    // interleaved order
  } burst_mode_t;

  function automatic burst_mode_t decode_mode(input logic [2:0] sel,
                                              input logic       ilv);
    burst_mode_t m;
    m.page = sel[2];
    m.lg   = sel[1:0];
    m.ilv  = ilv & ~sel[2];
    return m;
  endfunction

endpackage

// File: rtl/colgen_seq_ctl.sv
module colgen_seq_ctl
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv_sel,
  input  logic             stop,
  output logic             active,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output burst_mode_t      mode,
  output logic             done
);

  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic             act_q, act_d;
  logic [COL_W-1:0] beat_q, beat_d;
  logic [COL_W-1:0] base_q, base_d;
  burst_mode_t      mode_q, mode_d;
  logic [COL_W-1:0] last_idx;
  logic             fin_beat;
  logic             upd_en;

  // index of the closing beat of a finite burst
  assign last_idx = (ONE << mode_q.lg) - ONE;
  assign fin_beat = act_q & ~mode_q.page & (beat_q == last_idx);
  assign upd_en   = start | act_q;

  always_comb begin
    act_d  = act_q;
    beat_d = beat_q;
    base_d = base_q;
    mode_d = mode_q;
    if (start) begin
      act_d  = 1'b1;
      beat_d = '0;
      base_d = start_col;
      mode_d = decode_mode(len_sel, ilv_sel);
    end else if (act_q) begin
      if (stop || fin_beat) begin
        act_d = 1'b0;
      end else begin
        beat_d = beat_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      beat_q <= '0;
      base_q <= '0;
      mode_q <= '0;
    end else if (upd_en) begin
      act_q  <= act_d;
      beat_q <= beat_d;
      base_q <= base_d;
      mode_q <= mode_d;
    end
  end

  assign active = act_q;
  assign beat   = beat_q;
  assign base   = base_q;
  assign mode   = mode_q;
  assign done   = act_q & (stop | fin_beat);

endmodule

// File: rtl/colgen_addr_map.sv
module colgen_addr_map
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  burst_mode_t      mode,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  // bits that move within the burst: low lg bits, or all in full page
  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    assign wrap_mask[g] = mode.page | (g < int'(mode.lg));
  end

  assign sum     = base + beat;
  assign seq_col = (base & ~wrap_mask) | (sum & wrap_mask);
  assign ilv_col = base ^ (beat & wrap_mask);
  assign col     = mode.ilv ? ilv_col : seq_col;

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W     = 8,
  parameter int SYNC_DPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       len_sel,
  input  logic             ilv_sel,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             burst_valid,
  output logic             burst_done
);

  logic [SYNC_DPTH-1:0] rst_pipe;
  logic                 rst_int_n;
  logic                 act;
  logic [COL_W-1:0]     beat;
  logic [COL_W-1:0]     base;
  burst_mode_t          mode;
  logic                 done;

  // assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_DPTH-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_DPTH-1];

  colgen_seq_ctl #(.COL_W(COL_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .start_col (start_col),
    .len_sel   (len_sel),
    .ilv_sel   (ilv_sel),
    .stop      (stop),
    .active    (act),
    .beat      (beat),
    .base      (base),
    .mode      (mode),
    .done      (done)
  );

  colgen_addr_map #(.COL_W(COL_W)) u_map (
    .base (base),
    .beat (beat),
    .mode (mode),
    .col  (col_out)
  );

  assign burst_valid = act;
  assign burst_done  = done;

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             page_sel,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             burst_valid,
  input logic             burst_done
);

  logic page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     page_q <= 1'b0;
    else if (start) page_q <= page_sel;
  end

  a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (burst_valid && col_out == $past(start_col)));

  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && $past(burst_valid) && !$past(start) && !page_q)
      |-> col_out[COL_W-1:3] == $past(col_out[COL_W-1:3]));

  a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done && !start) |=> !burst_valid);

  a_r6_done_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> burst_valid);

  a_r7_page_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && page_q && !stop) |-> !burst_done);

  a_r8_idle_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !burst_valid && !start) |=> !burst_valid);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .start_col   (start_col),
  .page_sel    (len_sel[2]),
  .stop        (stop),
  .col_out     (col_out),
  .burst_valid (burst_valid),
  .burst_done  (burst_done)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [7:0] start_col;
  logic [2:0] len_sel;
  logic       ilv_sel;
  logic       stop;
  logic [7:0] col_out;
  logic       burst_valid;
  logic       burst_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sdram_burst_colgen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .len_sel(len_sel), .ilv_sel(ilv_sel), .stop(stop),
    .col_out(col_out), .burst_valid(burst_valid), .burst_done(burst_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at posedge+1; capture a start on the next edge
  task automatic kick(input logic [7:0] c, input logic [2:0] l, input logic il);
    start = 1'b1; start_col = c; len_sel = l; ilv_sel = il;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic beat_is(input string tag, input logic [7:0] c, input logic d);
    #1;
    chk({tag, " valid"}, burst_valid, 1);
    chk({tag, " col"}, col_out, c);
    chk({tag, " done"}, burst_done, d);
    @(posedge clk); #1;
  endtask

  task automatic idle_is(input string tag);
    #1;
    chk({tag, " valid"}, burst_valid, 0);
    chk({tag, " done"}, burst_done, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 0; stop = 0; start_col = 0; len_sel = 0; ilv_sel = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", burst_valid, 0);
    chk("R1 done in reset", burst_done, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_seq;
    kick(8'h2E, 3'd2, 1'b0);
    beat_is("R2 seq4 b0", 8'h2E, 0);
    beat_is("R3 seq4 b1", 8'h2F, 0);
    beat_is("R3 seq4 b2", 8'h2C, 0);
    beat_is("R6 seq4 b3", 8'h2D, 1);
    idle_is("R5 seq4 end");
    kick(8'hFD, 3'd3, 1'b0);
    beat_is("R3 seq8 b0", 8'hFD, 0);
    beat_is("R3 seq8 b1", 8'hFE, 0);
    beat_is("R3 seq8 b2", 8'hFF, 0);
    for (int i = 0; i < 4; i++) beat_is("R3 seq8 wrap", 8'hF8 + 8'(i), 0);
    beat_is("R6 seq8 last", 8'hFC, 1);
    idle_is("R5 seq8 end");
  endtask

  task automatic t_ilv;
    logic [7:0] exp8 [8] = '{8'h35, 8'h34, 8'h37, 8'h36, 8'h31, 8'h30, 8'h33, 8'h32};
    kick(8'h35, 3'd3, 1'b1);
    for (int i = 0; i < 8; i++) beat_is("R4 ilv8", exp8[i], i == 7);
    idle_is("R5 ilv8 end");
    kick(8'h9A, 3'd2, 1'b1);
    beat_is("R4 ilv4 b0", 8'h9A, 0);
    beat_is("R4 ilv4 b1", 8'h9B, 0);
    beat_is("R4 ilv4 b2", 8'h98, 0);
    beat_is("R4 ilv4 b3", 8'h99, 1);
    idle_is("R5 ilv4 end");
  endtask

  task automatic t_len;
    kick(8'h40, 3'd0, 1'b0);
    beat_is("R5 len1", 8'h40, 1);
    idle_is("R5 len1 end");
    kick(8'h41, 3'd1, 1'b0);
    beat_is("R5 len2 b0", 8'h41, 0);
    beat_is("R6 len2 b1", 8'h40, 1);
    idle_is("R5 len2 end");
  endtask

  task automatic t_full;
    kick(8'hFE, 3'd4, 1'b1);
    for (int i = 0; i < 259; i++) beat_is("R7 page", 8'(8'hFE + i), 0);
    stop = 1'b1;
    beat_is("R8 page stop", 8'(8'hFE + 259), 1);
    stop = 1'b0;
    idle_is("R8 page after stop");
    kick(8'h03, 3'd7, 1'b0);
    beat_is("R7 code7 b0", 8'h03, 0);
    beat_is("R7 code7 b1", 8'h04, 0);
    stop = 1'b1;
    beat_is("R8 code7 stop", 8'h05, 1);
    stop = 1'b0;
    idle_is("R8 code7 end");
  endtask

  task automatic t_stop;
    kick(8'h10, 3'd3, 1'b0);
    beat_is("R8 stop b0", 8'h10, 0);
    beat_is("R8 stop b1", 8'h11, 0);
    stop = 1'b1;
    beat_is("R8 stop b2", 8'h12, 1);
    idle_is("R8 stop idle1");
    idle_is("R8 stop idle2");
    stop = 1'b0;
    idle_is("R8 after stop");
  endtask

  task automatic t_restart;
    kick(8'h20, 3'd3, 1'b0);
    for (int i = 0; i < 3; i++) beat_is("R9 old", 8'h20 + 8'(i), 0);
    start = 1'b1; start_col = 8'h50; len_sel = 3'd1; ilv_sel = 1'b0;
    beat_is("R9 old b3", 8'h23, 0);
    start = 1'b0;
    beat_is("R9 new b0", 8'h50, 0);
    beat_is("R9 new b1", 8'h51, 1);
    idle_is("R9 new end");
    kick(8'h60, 3'd2, 1'b0);
    len_sel = 3'd3; ilv_sel = 1'b1;
    beat_is("R9 hold b0", 8'h60, 0);
    beat_is("R9 hold b1", 8'h61, 0);
    beat_is("R9 hold b2", 8'h62, 0);
    beat_is("R9 hold b3", 8'h63, 1);
    idle_is("R9 hold end");
  endtask

  task automatic t_chain;
    kick(8'h70, 3'd1, 1'b0);
    beat_is("R10 a b0", 8'h70, 0);
    start = 1'b1; start_col = 8'h80; len_sel = 3'd1; ilv_sel = 1'b0;
    beat_is("R10 a b1", 8'h71, 1);
    start = 1'b0;
    beat_is("R10 b b0", 8'h80, 0);
    beat_is("R10 b b1", 8'h81, 1);
    idle_is("R10 end");
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_seq();
    t_ilv();
    t_len();
    t_full();
    t_stop();
    t_restart();
    t_chain();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule